// File: doc/BRIEF.md
# Battery Charge Cycle Sequencer

This block walks a rechargeable battery through one charge cycle. A cycle can start with a forced discharge. It then waits in a qualification phase until the cell voltage and temperature lie inside their limits, runs fast charge, and may run a reduced-rate top-off. It ends in a maintenance trickle. Analog comparators and slope detectors sit outside the block. They deliver single-bit flags: cell above its maximum, cell below end-of-discharge, temperature past the cutoff, temperature hot or cold outside the qualification window, and the slope and voltage-drop termination events. A timebase tick of 1/8 s paces every timed behaviour.

The block drives four things: a discharge control line, a 2-bit charge phase code for a downstream current gate modulator, and two status LED lines whose meaning depends on a display mode. A timed over-voltage window separates a full battery from a removed one. A cycle restarts on supply becoming valid, on the enable input rising, on a battery being inserted, or on a discharge command.

Top module: `chg_cycle_ctrl`

## Requirements
- R1: While `supply_ok_i` or `chg_enable_i` is low, the block is idle one cycle later: `dis_o`=0, `phase_o`=0, both LEDs 0. Reset gives the same idle outputs.
- R2: When supply and enable are both high while idle, a new cycle starts. With `dis_cmd_ni` high it enters charge pending, which drives phase code 1 (trickle).
- R3: A cycle started with `dis_cmd_ni` held low begins in discharge. A falling edge on `dis_cmd_ni` forces discharge from any state. Discharge drives `dis_o`=1 and phase code 0 until `cell_below_edv_i` is seen, then moves to charge pending.
- R4: Pending moves to fast charge (phase code 2) only when all of these hold: cell neither below end-of-discharge nor above maximum, `temp_hot_i`=0, `temp_cut_i`=0, and the cold check passes. Otherwise pending lasts with no time limit.
- R5: Fast charge ends on any of: slope, voltage drop, temperature cutoff, cold fault, or the safety timer. It goes to top-off (phase code 3) when `topoff_en_i`=1, else to charge complete (phase code 1).
- R6: Top-off ends only on temperature cutoff, the safety timer or over-voltage; slope and voltage-drop flags are ignored there. The safety timer restarts on entry to top-off.
- R7: The safety timer expires after SAFE_UNIT_TICKS << `cfg_timer_i` ticks spent in the phase.
- R8: `cell_over_max_i` in any active state turns phase code, `dis_o` and both LEDs off on the next cycle. If the flag clears before MCV_TICKS ticks have passed, the state becomes charge complete. If it is still set at MCV_TICKS, the state becomes battery absent.
- R9: In battery absent, a falling edge on `cell_over_max_i` starts a new cycle.
- R10: With `peak_mode_i`=1, the cold fault (`temp_cold_i`) neither blocks qualification nor ends fast charge.
- R11: LEDs {led1,led2} by `disp_mode_i`:
  - Mode 0 or 3: pending or discharge 11, fast 01, top-off or complete 10, else 00.
  - Mode 1: pending 10, discharge 01, top-off 11, else 00.
  - Mode 2: pending or discharge 0 and blink, fast 01, top-off or complete 10, else 00.
- R12: The blink signal starts at 0 after reset and toggles on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase pulse, one cycle wide, every 1/8 s |
| supply_ok_i | input | 1 | Supply at valid level |
| chg_enable_i | input | 1 | Charge enable; low inhibits and idles |
| dis_cmd_ni | input | 1 | Discharge command, active low |
| cell_over_max_i | input | 1 | Cell voltage above maximum |
| cell_below_edv_i | input | 1 | Cell voltage below end-of-discharge |
| temp_cut_i | input | 1 | Temperature past cutoff (too hot, terminate) |
| temp_hot_i | input | 1 | Temperature above qualification window |
| temp_cold_i | input | 1 | Temperature below window (cold fault) |
| term_slope_i | input | 1 | Temperature-slope termination event |
| term_vdrop_i | input | 1 | Voltage-drop or peak termination event |
| peak_mode_i | input | 1 | Peak-detect mode; cold fault ignored |
| topoff_en_i | input | 1 | Run top-off after fast charge |
| cfg_timer_i | input | 3 | Safety timer length code |
| disp_mode_i | input | 2 | LED display mode |
| dis_o | output | 1 | Discharge control |
| phase_o | output | 2 | Phase code: 0 none, 1 trickle, 2 fast, 3 top-off |
| led1_o | output | 1 | Status LED 1 |
| led2_o | output | 1 | Status LED 2 |

## Verification
The sequencer runs through several kinds of cycle, each with a different end:
- a slope event alone, and the safety timer alone;
- a voltage drop followed by top-off;
- a cutoff during top-off;
- over-voltage that clears inside the window against over-voltage that holds past it.

These tell the charge-complete path from the removal path, and they show that the top-off timer truly restarts. Termination flags held high through top-off confirm that top-off ignores them.

Qualification runs with hot, cold and low-voltage flags, with peak mode toggled, so the bench can see which fault holds pending. Cycles start four ways: enable rising, command held low, a command edge from fast charge, and battery reinsertion after absent. Every display mode is checked, and the blink phase is predicted from the number of ticks issued.

// File: rtl/chg_pkg.sv
package chg_pkg;
  typedef enum logic [2:0] {
    ST_OFF, ST_DISCH, ST_PEND, ST_FAST, ST_TOPOFF, ST_DONE, ST_MCV, ST_ABSENT
  } chg_state_e;

  localparam logic [1:0] PH_NONE    = 2'd0;
  localparam logic [1:0] PH_TRICKLE = 2'd1;
  localparam logic [1:0] PH_FAST    = 2'd2;
  localparam logic [1:0] PH_TOPOFF  = 2'd3;
endpackage

// File: rtl/chg_span_timer.sv
module chg_span_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   cnt_q <= '0;
    else if (clr_i)                                cnt_q <= '0;
    else if (run_i && tick_i && cnt_q < limit_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q >= limit_i);
endmodule

// File: rtl/chg_led_decode.sv
module chg_led_decode
  import chg_pkg::*;
(
  input  chg_state_e state_i,
  input  logic [1:0] mode_i,
  input  logic       blink_i,
  output logic       led1_o,
  output logic       led2_o
);
  always_comb begin
    {led1_o, led2_o} = 2'b00;
    unique case (mode_i)
      2'd1: begin
        case (state_i)
          ST_PEND:   {led1_o, led2_o} = 2'b10;
          ST_DISCH:  {led1_o, led2_o} = 2'b01;
          ST_TOPOFF: {led1_o, led2_o} = 2'b11;
          default:   {led1_o, led2_o} = 2'b00;
        endcase
      end
      2'd2: begin
        case (state_i)
          ST_PEND, ST_DISCH:  {led1_o, led2_o} = {1'b0, blink_i};
          ST_FAST:            {led1_o, led2_o} = 2'b01;
          ST_TOPOFF, ST_DONE: {led1_o, led2_o} = 2'b10;
          default:            {led1_o, led2_o} = 2'b00;
        endcase
      end
      default: begin
        case (state_i)
          ST_PEND, ST_DISCH:  {led1_o, led2_o} = 2'b11;
          ST_FAST:            {led1_o, led2_o} = 2'b01;
          ST_TOPOFF, ST_DONE: {led1_o, led2_o} = 2'b10;
          default:            {led1_o, led2_o} = 2'b00;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/chg_cycle_ctrl.sv
module chg_cycle_ctrl
  import chg_pkg::*;
#(
  parameter int SAFE_UNIT_TICKS = 1440,
  parameter int MCV_TICKS       = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       supply_ok_i,
  input  logic       chg_enable_i,
  input  logic       dis_cmd_ni,
  input  logic       cell_over_max_i,
  input  logic       cell_below_edv_i,
  input  logic       temp_cut_i,
  input  logic       temp_hot_i,
  input  logic       temp_cold_i,
  input  logic       term_slope_i,
  input  logic       term_vdrop_i,
  input  logic       peak_mode_i,
  input  logic       topoff_en_i,
  input  logic [2:0] cfg_timer_i,
  input  logic [1:0] disp_mode_i,
  output logic       dis_o,
  output logic [1:0] phase_o,
  output logic       led1_o,
  output logic       led2_o
);
  localparam int CW = $clog2(SAFE_UNIT_TICKS * 128 + 1);
  localparam int MW = $clog2(MCV_TICKS + 1);

  chg_state_e state_q, state_n, start_st;
  logic dcmd_q, over_q, blink_q;
  logic run, dcmd_fall, over_fall, cold_bad, qualified, fast_end;
  logic safe_done, mcv_done, st_change;
  logic [CW-1:0] safe_lim;

  assign run       = supply_ok_i && chg_enable_i;
  assign dcmd_fall = dcmd_q && !dis_cmd_ni;
  assign over_fall = over_q && !cell_over_max_i;
  assign cold_bad  = temp_cold_i && !peak_mode_i;
  assign qualified = !cell_below_edv_i && !cell_over_max_i && !temp_hot_i &&
                     !temp_cut_i && !cold_bad;
  assign fast_end  = term_slope_i || term_vdrop_i || temp_cut_i || cold_bad || safe_done;
  assign start_st  = dis_cmd_ni ? ST_PEND : ST_DISCH;
  assign safe_lim  = CW'(SAFE_UNIT_TICKS) << cfg_timer_i;
  assign st_change = (state_n != state_q);

  always_comb begin
    state_n = state_q;
    if (!run)                  state_n = ST_OFF;
    else if (dcmd_fall)        state_n = ST_DISCH;
    else if (state_q == ST_OFF) state_n = start_st;
    else if (cell_over_max_i && state_q != ST_MCV && state_q != ST_ABSENT)
                               state_n = ST_MCV;
    else begin
      case (state_q)
        ST_DISCH:  if (cell_below_edv_i) state_n = ST_PEND;
        ST_PEND:   if (qualified)        state_n = ST_FAST;
        ST_FAST:   if (fast_end)         state_n = topoff_en_i ? ST_TOPOFF : ST_DONE;
        ST_TOPOFF: if (temp_cut_i || safe_done) state_n = ST_DONE;
        ST_MCV: begin
          if (!cell_over_max_i) state_n = ST_DONE;
          else if (mcv_done)    state_n = ST_ABSENT;
        end
        ST_ABSENT: if (over_fall)        state_n = start_st;
        default:   state_n = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      dcmd_q  <= 1'b1;
      over_q  <= 1'b0;
      blink_q <= 1'b0;
    end else begin
      state_q <= state_n;
      dcmd_q  <= dis_cmd_ni;
      over_q  <= cell_over_max_i;
      if (tick_i) blink_q <= ~blink_q;
    end
  end

  chg_span_timer #(.W(CW)) u_safe_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (st_change),
    .run_i   (state_q == ST_FAST || state_q == ST_TOPOFF),
    .tick_i  (tick_i),
    .limit_i (safe_lim),
    .done_o  (safe_done)
  );

  chg_span_timer #(.W(MW)) u_mcv_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (st_change),
    .run_i   (state_q == ST_MCV),
    .tick_i  (tick_i),
    .limit_i (MW'(MCV_TICKS)),
    .done_o  (mcv_done)
  );

  always_comb begin
    case (state_q)
      ST_PEND, ST_DONE: phase_o = PH_TRICKLE;
      ST_FAST:          phase_o = PH_FAST;
      ST_TOPOFF:        phase_o = PH_TOPOFF;
      default:          phase_o = PH_NONE;
    endcase
  end

  assign dis_o = (state_q == ST_DISCH);

  chg_led_decode u_led (
    .state_i (state_q),
    .mode_i  (disp_mode_i),
    .blink_i (blink_q),
    .led1_o  (led1_o),
    .led2_o  (led2_o)
  );
endmodule

// File: rtl/chg_cycle_ctrl_chk.sv
module chg_cycle_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       supply_ok_i,
  input logic       chg_enable_i,
  input logic       dis_cmd_ni,
  input logic       cell_over_max_i,
  input logic       cell_below_edv_i,
  input logic       temp_cut_i,
  input logic       temp_hot_i,
  input logic       temp_cold_i,
  input logic       peak_mode_i,
  input logic       dis_o,
  input logic [1:0] phase_o,
  input logic       led1_o,
  input logic       led2_o
);
  logic act;
  assign act = supply_ok_i && chg_enable_i;

  a_r1_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act |=> (phase_o == 2'd0 && !dis_o && !led1_o && !led2_o));

  a_r3_cmd_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && $fell(dis_cmd_ni)) |=> dis_o);

  a_r3_dis_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && dis_o && cell_below_edv_i && !cell_over_max_i && !$fell(dis_cmd_ni))
      |=> (!dis_o && phase_o == 2'd1));

  a_r4_fast_qual: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase_o == 2'd2) |-> $past(!cell_below_edv_i && !cell_over_max_i &&
      !temp_hot_i && !temp_cut_i && (peak_mode_i || !temp_cold_i)));

  a_r6_topoff_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase_o == 2'd3) |-> $past(phase_o) == 2'd2);

  a_r8_over_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && cell_over_max_i && !$fell(dis_cmd_ni) && (phase_o != 2'd0 || dis_o))
      |=> (phase_o == 2'd0 && !dis_o && !led1_o && !led2_o));
endmodule

bind chg_cycle_ctrl chg_cycle_ctrl_chk u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .supply_ok_i      (supply_ok_i),
  .chg_enable_i     (chg_enable_i),
  .dis_cmd_ni       (dis_cmd_ni),
  .cell_over_max_i  (cell_over_max_i),
  .cell_below_edv_i (cell_below_edv_i),
  .temp_cut_i       (temp_cut_i),
  .temp_hot_i       (temp_hot_i),
  .temp_cold_i      (temp_cold_i),
  .peak_mode_i      (peak_mode_i),
  .dis_o            (dis_o),
  .phase_o          (phase_o),
  .led1_o           (led1_o),
  .led2_o           (led2_o)
);

// File: tb/chg_cycle_ctrl_bench.sv
`timescale 1ns/1ps
module chg_cycle_ctrl_bench;
  logic clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0;
  logic supply_ok_i = 1'b0, chg_enable_i = 1'b0, dis_cmd_ni = 1'b1;
  logic cell_over_max_i = 1'b0, cell_below_edv_i = 1'b0;
  logic temp_cut_i = 1'b0, temp_hot_i = 1'b0, temp_cold_i = 1'b0;
  logic term_slope_i = 1'b0, term_vdrop_i = 1'b0, peak_mode_i = 1'b0, topoff_en_i = 1'b0;
  logic [2:0] cfg_timer_i = 3'd1;
  logic [1:0] disp_mode_i = 2'd0;
  logic dis_o, led1_o, led2_o;
  logic [1:0] phase_o;

  int checks = 0, errors = 0, nticks = 0;

  always #2.5 clk_i = ~clk_i;

  chg_cycle_ctrl #(.SAFE_UNIT_TICKS(2), .MCV_TICKS(3)) u_chg_cycle_ctrl (.*);

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic pulse_tick();
    tick_i = 1'b1;
    cyc();
    tick_i = 1'b0;
    nticks++;
  endtask

  // expected vector: {dis, phase[1:0], led1, led2}
  task automatic chk(string tag, logic [4:0] exp);
    logic [4:0] act;
    act = {dis_o, phase_o, led1_o, led2_o};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic restart();
    chg_enable_i = 1'b0;
    cyc();
    chg_enable_i = 1'b1;
    cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset idle", 5'b0_00_00);
    rst_ni = 1'b1;
    cyc();
    chk("R1 disabled idle", 5'b0_00_00);

    // start and slope termination, mode 0
    supply_ok_i = 1'b1; chg_enable_i = 1'b1;
    cyc(); chk("R2 start pending", 5'b0_01_11);
    cyc(); chk("R4 enter fast", 5'b0_10_01);
    term_slope_i = 1'b1;
    cyc(); chk("R5 slope to complete", 5'b0_01_10);
    term_slope_i = 1'b0;

    // safety timer: sel=1, unit 2 -> 4 ticks
    chg_enable_i = 1'b0;
    cyc(); chk("R1 inhibit idle", 5'b0_00_00);
    chg_enable_i = 1'b1;
    cyc(); cyc(); chk("R4 fast again", 5'b0_10_01);
    repeat (3) pulse_tick();
    cyc(); chk("R7 timer not yet", 5'b0_10_01);
    pulse_tick();
    cyc(); chk("R7 timer expiry", 5'b0_01_10);

    // top-off with timer restart and ignored flags
    topoff_en_i = 1'b1;
    restart(); cyc();
    repeat (2) pulse_tick();
    term_vdrop_i = 1'b1;
    cyc(); chk("R5 vdrop to topoff", 5'b0_11_10);
    term_slope_i = 1'b1;
    cyc(); cyc(); chk("R6 topoff ignores slope/vdrop", 5'b0_11_10);
    repeat (3) pulse_tick();
    cyc(); chk("R6 topoff timer restarted", 5'b0_11_10);
    pulse_tick();
    cyc(); chk("R6 topoff timer end", 5'b0_01_10);
    term_vdrop_i = 1'b0; term_slope_i = 1'b0;

    // cutoff in top-off
    restart(); cyc();
    term_vdrop_i = 1'b1; cyc(); term_vdrop_i = 1'b0;
    chk("R5 topoff entry", 5'b0_11_10);
    temp_cut_i = 1'b1;
    cyc(); chk("R6 cutoff ends topoff", 5'b0_01_10);
    temp_cut_i = 1'b0; topoff_en_i = 1'b0;

    // qualification: hot
    temp_hot_i = 1'b1;
    restart();
    repeat (3) cyc();
    chk("R4 hot holds pending", 5'b0_01_11);
    temp_hot_i = 1'b0;
    cyc(); chk("R4 qualified fast", 5'b0_10_01);

    // cold and peak mode
    temp_cold_i = 1'b1;
    restart(); cyc();
    chk("R4 cold holds pending", 5'b0_01_11);
    peak_mode_i = 1'b1;
    cyc(); chk("R10 peak ignores cold qual", 5'b0_10_01);
    cyc(); chk("R10 peak ignores cold in fast", 5'b0_10_01);
    peak_mode_i = 1'b0;
    cyc(); chk("R5 cold ends fast", 5'b0_01_10);
    temp_cold_i = 1'b0;

    // over-voltage returning inside window
    restart(); cyc();
    cell_over_max_i = 1'b1;
    cyc(); chk("R8 over-voltage off", 5'b0_00_00);
    repeat (2) pulse_tick();
    chk("R8 window open", 5'b0_00_00);
    cell_over_max_i = 1'b0;
    cyc(); chk("R8 return gives complete", 5'b0_01_10);

    // over-voltage held past window
    restart(); cyc();
    cell_over_max_i = 1'b1;
    cyc();
    repeat (3) pulse_tick();
    cyc(); cyc(); chk("R8 held gives absent", 5'b0_00_00);
    cell_over_max_i = 1'b0;
    cyc(); chk("R9 reinsert restarts pending", 5'b0_01_11);
    cyc(); chk("R9 fast after reinsert", 5'b0_10_01);

    // discharge edge from fast
    dis_cmd_ni = 1'b0;
    cyc(); chk("R3 edge forces discharge", 5'b1_00_11);
    dis_cmd_ni = 1'b1;
    cyc(); chk("R3 discharge held", 5'b1_00_11);
    cell_below_edv_i = 1'b1;
    cyc(); chk("R3 edv ends discharge", 5'b0_01_11);
    cyc(); chk("R4 low voltage holds pending", 5'b0_01_11);
    cell_below_edv_i = 1'b0;
    cyc(); chk("R4 fast after edv", 5'b0_10_01);

    // command held low across a new cycle
    dis_cmd_ni = 1'b0;
    cyc();
    restart(); chk("R3 held low starts discharge", 5'b1_00_11);
    cell_below_edv_i = 1'b1;
    cyc(); chk("R3 to pending", 5'b0_01_11);
    cell_below_edv_i = 1'b0; dis_cmd_ni = 1'b1;
    cyc(); chk("R4 fast", 5'b0_10_01);

    // display modes
    disp_mode_i = 2'd1;
    #1 chk("R11 mode1 fast", 5'b0_10_00);
    term_slope_i = 1'b1; cyc(); term_slope_i = 1'b0;
    chk("R11 mode1 complete", 5'b0_01_00);
    dis_cmd_ni = 1'b0; cyc(); dis_cmd_ni = 1'b1;
    chk("R11 mode1 discharge", 5'b1_00_01);
    cell_below_edv_i = 1'b1;
    cyc(); chk("R11 mode1 pending", 5'b0_01_10);
    disp_mode_i = 2'd2;
    #1 chk("R12 blink phase", {3'b0_01, 1'b0, nticks[0]});
    pulse_tick();
    chk("R12 blink toggles", {3'b0_01, 1'b0, nticks[0]});
    pulse_tick();
    chk("R12 blink toggles back", {3'b0_01, 1'b0, nticks[0]});
    cell_below_edv_i = 1'b0;
    cyc(); chk("R11 mode2 fast", 5'b0_10_01);
    disp_mode_i = 2'd3;
    #1 chk("R11 mode3 as mode0", 5'b0_10_01);

    supply_ok_i = 1'b0;
    cyc(); chk("R1 supply loss idle", 5'b0_00_00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule